// File: doc/BRIEF.md
# DMA Interrupt Pending and Mask Unit

This block gathers the interrupt events of a DMA engine with `NUM_SRC` channels (32 by default) into two registers. A pending register latches a one-cycle pulse from any source and holds it until software clears it. A mask register can disable each source. The block drives a single combined request toward the peripheral interrupt level. That request is high whenever some source is both pending and enabled.

To help the handler choose which channel to service, the block also reports the position of the lowest-numbered source that is pending and enabled, together with a valid flag. Software reads either register through a read port. It clears pending bits by writing ones and sets the mask by writing a full word. After servicing, the handler writes a one to the reported bit.

Top module: `dma_irq_unit`

## Requirements
- R1: While reset is asserted and just after it is released, the pending register reads all zeros, the mask register reads all ones, `irq_req` and `svc_valid` are low and `svc_index` is 0.
- R2: A high bit `src_pulse[k]` at a clock edge sets pending bit k (the same bit position, no reversal). This happens whether or not source k is masked.
- R3: A write with `reg_sel`=0 is write-one-to-clear on the pending register. Each data bit at 1 clears that pending bit at the edge, and each bit at 0 leaves its pending bit unchanged.
- R4: A write with `reg_sel`=1 loads the whole data word into the mask register. Mask bit k at 1 disables source k. Without such a write the mask holds its value.
- R5: `irq_req` is high exactly when at least one bit is pending with its mask bit at 0. It follows the register state with no extra cycle of delay.
- R6: When some source is pending and enabled, `svc_valid` is high and `svc_index` is the lowest such bit position.
- R7: When no source is pending and enabled, `svc_valid` is low and `svc_index` is 0.
- R8: If a pulse and a clearing write reach the same pending bit at the same edge, the bit ends up set.
- R9: `reg_rdata` shows the pending register when `reg_rd_sel`=0 and the mask register when `reg_rd_sel`=1. It is combinational from the current register state.
- R10: Writing all ones to the pending register and then all ones to the mask register leaves every source cleared and masked, with `irq_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | NUM_SRC | One-cycle event per DMA source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 pending (clear by ones), 1 mask |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rd_sel | input | 1 | Read target: 0 pending, 1 mask |
| reg_rdata | output | NUM_SRC | Read data |
| irq_req | output | 1 | Combined request |
| svc_valid | output | 1 | A source is pending and enabled |
| svc_index | output | $clog2(NUM_SRC) | Lowest pending enabled source |

## Verification
The hardest case to reach from the ports is a clearing write and a new pulse landing on the same bit at the same edge. It is equally hard to place a pulse on a masked bit that sits below the lowest enabled one. The first case decides R8. The second shows whether the index search ignores masked bits. The driver produces both in a single step by presenting a pulse vector and a write word that overlap on chosen bits. It also scans pulses at bit 0 and at bit `NUM_SRC-1`. A pseudo-random phase then mixes pulses, partial clears and mask rewrites, each compared against a bench model of the two registers.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    typedef enum logic {
        SEL_PEND = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    localparam int unsigned DEF_NUM_SRC = 32;
    localparam int unsigned DEF_GRP_W   = 8;

endpackage

// File: rtl/dma_irq_pend_bank.sv
module dma_irq_pend_bank #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } pend_st_t;

    pend_st_t st_d, st_q;

    // Clear first, then set: a pulse in the same cycle dominates.
    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: '0};
        else        st_q <= st_d;
    end

    assign pend = st_q.bits;

endmodule

// File: rtl/dma_irq_mask_bank.sv
module dma_irq_mask_bank #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_SRC-1:0] load_val,
    output logic [NUM_SRC-1:0] mask
);

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.bits = load_val;
    end

    // Every source comes out of reset disabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bits: '1};
        else        st_q <= st_d;
    end

    assign mask = st_q.bits;

endmodule

// File: rtl/dma_irq_lowest_find.sv
module dma_irq_lowest_find #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned GRP_W   = 8
) (
    input  logic [NUM_SRC-1:0]         vec,
    output logic                       found,
    output logic [$clog2(NUM_SRC)-1:0] idx
);

    localparam int unsigned NUM_GRP = NUM_SRC / GRP_W;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);
    localparam int unsigned LOC_W   = $clog2(GRP_W);

    logic [NUM_GRP-1:0]       grp_any;
    logic [NUM_GRP*LOC_W-1:0] grp_loc;

    // First level: each group finds its own lowest bit.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [GRP_W-1:0] slice;
        logic [LOC_W-1:0] loc;

        assign slice = vec[g*GRP_W +: GRP_W];

        always_comb begin
            loc = '0;
            for (int b = GRP_W - 1; b >= 0; b--) begin
                if (slice[b]) loc = LOC_W'(b);
            end
        end

        assign grp_any[g]                 = |slice;
        assign grp_loc[g*LOC_W +: LOC_W]  = loc;
    end

    // Second level: the lowest group with a hit wins.
    always_comb begin
        idx = '0;
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                idx = IDX_W'(g * GRP_W) + IDX_W'(grp_loc[g*LOC_W +: LOC_W]);
            end
        end
    end

    assign found = |grp_any;

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = DEF_NUM_SRC,
    parameter int unsigned GRP_W   = DEF_GRP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_pulse,
    input  logic                       reg_wr_en,
    input  logic                       reg_sel,
    input  logic [NUM_SRC-1:0]         reg_wdata,
    input  logic                       reg_rd_sel,
    output logic [NUM_SRC-1:0]         reg_rdata,
    output logic                       irq_req,
    output logic                       svc_valid,
    output logic [$clog2(NUM_SRC)-1:0] svc_index
);

    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] clr_vec;
        logic               mask_load;
        logic [NUM_SRC-1:0] enabled;
        logic [NUM_SRC-1:0] rdata;
    } ctl_t;

    ctl_t               ctl;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic               find_hit;
    logic [IDX_W-1:0]   find_idx;

    always_comb begin
        ctl           = '0;
        ctl.mask_load = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_MASK);
        if (reg_wr_en && (reg_sel_e'(reg_sel) == SEL_PEND)) ctl.clr_vec = reg_wdata;
        ctl.enabled   = pend_vec & ~mask_vec;
        ctl.rdata     = (reg_sel_e'(reg_rd_sel) == SEL_MASK) ? mask_vec : pend_vec;
    end

    dma_irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (src_pulse),
        .clr_vec (ctl.clr_vec),
        .pend    (pend_vec)
    );

    dma_irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl.mask_load),
        .load_val (reg_wdata),
        .mask     (mask_vec)
    );

    dma_irq_lowest_find #(.NUM_SRC(NUM_SRC), .GRP_W(GRP_W)) u_find (
        .vec   (ctl.enabled),
        .found (find_hit),
        .idx   (find_idx)
    );

    assign reg_rdata = ctl.rdata;
    assign irq_req   = |ctl.enabled;
    assign svc_valid = find_hit;
    assign svc_index = find_hit ? find_idx : '0;

endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk #(
    parameter int unsigned NUM_SRC = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         src_pulse,
    input logic                       reg_wr_en,
    input logic                       reg_sel,
    input logic [NUM_SRC-1:0]         reg_wdata,
    input logic [NUM_SRC-1:0]         pend_q,
    input logic [NUM_SRC-1:0]         mask_q,
    input logic                       irq_req,
    input logic                       svc_valid,
    input logic [$clog2(NUM_SRC)-1:0] svc_index
);

    logic               past_ok;
    logic [NUM_SRC-1:0] clr_w;
    logic               mload_w;
    logic [NUM_SRC-1:0] below_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign clr_w   = (reg_wr_en && !reg_sel) ? reg_wdata : '0;
    assign mload_w = reg_wr_en && reg_sel;
    assign below_w = ~({NUM_SRC{1'b1}} << svc_index);

    // R2
    pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend_q & $past(clr_w & ~src_pulse)) == '0));

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (((pend_q ^ $past(pend_q)) & $past(~clr_w & ~src_pulse)) == '0));

    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mload_w)) |-> (mask_q == $past(reg_wdata)));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(mload_w)) |-> $stable(mask_q));

    // R5
    req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == svc_valid);

    // R6
    idx_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (pend_q[svc_index] && !mask_q[svc_index]));

    // R6
    idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> ((pend_q & ~mask_q & below_w) == '0));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_valid |-> (svc_index == '0 && !irq_req));

endmodule

bind dma_irq_unit dma_irq_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .pend_q    (pend_vec),
    .mask_q    (mask_vec),
    .irq_req   (irq_req),
    .svc_valid (svc_valid),
    .svc_index (svc_index)
);

// File: tb/dma_irq_unit_tb.sv
module dma_irq_unit_tb;

    localparam int N  = 32;
    localparam int IW = $clog2(N);

    typedef struct {
        string        tag;
        logic [N-1:0] pend;
        logic [N-1:0] mask;
        logic         req;
        logic         valid;
        logic [IW-1:0] idx;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_pulse = '0;
    logic          reg_wr_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic [N-1:0]  reg_wdata = '0;
    logic          reg_rd_sel = 1'b0;
    logic [N-1:0]  reg_rdata;
    logic          irq_req;
    logic          svc_valid;
    logic [IW-1:0] svc_index;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exp_t         sb_q[$];
    logic [N-1:0] m_pend;
    logic [N-1:0] m_mask;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    dma_irq_unit #(.NUM_SRC(N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_pulse  (src_pulse),
        .reg_wr_en  (reg_wr_en),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rd_sel (reg_rd_sel),
        .reg_rdata  (reg_rdata),
        .irq_req    (irq_req),
        .svc_valid  (svc_valid),
        .svc_index  (svc_index)
    );

    function automatic exp_t make_exp(string tag);
        exp_t e;
        logic [N-1:0] en;
        en      = m_pend & ~m_mask;
        e.tag   = tag;
        e.pend  = m_pend;
        e.mask  = m_mask;
        e.req   = |en;
        e.valid = |en;
        e.idx   = '0;
        for (int b = N - 1; b >= 0; b--) if (en[b]) e.idx = IW'(b);
        return e;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, update the model, queue the expectation.
    task automatic step(logic [N-1:0] pulse, logic wr, logic sel,
                        logic [N-1:0] data, string tag);
        @(negedge clk);
        src_pulse = pulse;
        reg_wr_en = wr;
        reg_sel   = sel;
        reg_wdata = data;
        @(posedge clk);
        if (wr && !sel) m_pend = m_pend & ~data;
        if (wr && sel)  m_mask = data;
        m_pend = m_pend | pulse;
        #1;
        sb_q.push_back(make_exp(tag));
        wait (sb_q.size() == 0);
        src_pulse = '0;
        reg_wr_en = 1'b0;
    endtask

    // Monitor: pop expectations and compare against the ports.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                exp_t e;
                e = sb_q[0];
                reg_rd_sel = 1'b0;
                #1;
                chk({e.tag, " R9 pending"}, reg_rdata, e.pend);
                reg_rd_sel = 1'b1;
                #1;
                chk({e.tag, " R9 mask"}, reg_rdata, e.mask);
                chk({e.tag, " R5 irq_req"}, N'(irq_req), N'(e.req));
                chk({e.tag, " R6/R7 svc_valid"}, N'(svc_valid), N'(e.valid));
                chk({e.tag, " R6/R7 svc_index"}, N'(svc_index), N'(e.idx));
                void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pend = '0;
        m_mask = '1;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values, sampled while reset is still asserted
        sb_q.push_back(make_exp("R1 in reset"));
        wait (sb_q.size() == 0);
        @(negedge clk);
        rst_n = 1'b1;
        step('0, 1'b0, 1'b0, '0, "R1 after release");

        // R2: masked sources still latch pending, with no request
        step(32'h0000_0001, 1'b0, 1'b0, '0, "R2 bit0 masked");
        step(32'h8000_0000, 1'b0, 1'b0, '0, "R2 bit31 masked");
        step(32'h0010_0400, 1'b0, 1'b0, '0, "R2 mid bits masked");

        // R4 / R6: enable only high bits; masked bit0 must be skipped
        step('0, 1'b1, 1'b1, 32'h0000_FFFF, "R4 unmask upper half");
        step('0, 1'b1, 1'b1, 32'h7FFF_FFFF, "R6 only bit31 enabled");
        step('0, 1'b1, 1'b1, 32'h0000_0000, "R6 all enabled lowest bit0");

        // R3: write-one-to-clear, zeros leave bits alone
        step('0, 1'b1, 1'b0, 32'h0000_0000, "R3 zero write no effect");
        step('0, 1'b1, 1'b0, 32'h0000_0001, "R3 clear bit0");
        step('0, 1'b1, 1'b0, 32'h0000_0400, "R3 clear bit10");
        step('0, 1'b1, 1'b0, 32'h8010_0000, "R3/R7 clear rest");

        // R8: set and clear on the same bit at the same edge
        step(32'h0000_0020, 1'b0, 1'b0, '0, "R8 setup bit5");
        step(32'h0000_0021, 1'b1, 1'b0, 32'h0000_0023, "R8 set beats clear");
        step('0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R8 cleanup");

        // R4: mask rewrite moves the service index
        step(32'h0000_8100, 1'b0, 1'b0, '0, "R6 bits8 and 15");
        step('0, 1'b1, 1'b1, 32'h0000_0100, "R4 mask bit8 index 15");
        step('0, 1'b1, 1'b1, 32'h0000_8100, "R4/R7 both masked");

        // R10: initialization sequence
        step(32'h00F0_000F, 1'b0, 1'b0, '0, "R10 preload");
        step('0, 1'b1, 1'b1, 32'h0, "R10 open mask");
        step('0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R10 clear all");
        step('0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R10 mask all");

        // Scan every single source with the mask open
        step('0, 1'b1, 1'b1, 32'h0, "R4 open for scan");
        for (int k = 0; k < N; k++) begin
            step(N'(1) << k, 1'b0, 1'b0, '0, "R2/R6 single source");
            step('0, 1'b1, 1'b0, N'(1) << k, "R3 single clear");
        end

        // Mixed pseudo-random traffic
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] p, d;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            p = lfsr & (lfsr >> 3) & (lfsr << 7);
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            d = lfsr;
            step(p, lfsr[1] & lfsr[9], lfsr[20], d, "R2/R3/R4/R8 mixed");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule